// File: doc/BRIEF.md
# Uncached Store Holding Buffer

This block sits between the write-back stage of a processor pipeline and a slower external system interface. It holds exactly one uncached store, made of an address, a data word and byte enables. The pipeline can hand off an uncached store and keep running. The buffer then offers the store on the external side through a request/accept handshake. The external side accepts the store when it raises its ready signal while a request is up.

The external interface takes at most one store every four external clock cycles. The external clock is the pipeline clock divided by a programmable divisor, so the block enforces a minimum spacing of four times the divisor, counted in pipeline cycles, between two accepted stores. A down-counter is loaded when a store is accepted. A new request can go out only once that counter has reached zero. The pipeline is told to stall only when a second uncached store arrives at write-back while the first is still held and is not being accepted in that same cycle.

The controller has two states. `SLOT_EMPTY` moves to `SLOT_HELD` on the CAPTURE transition, which fires when a store arrives. `SLOT_HELD` returns to `SLOT_EMPTY` on the DRAIN transition: the held store is accepted and no new store arrives. `SLOT_HELD` stays in `SLOT_HELD` on the REFILL transition, where a store is accepted and a new one is captured in the same cycle. It also stays there on the WAIT transition, when nothing is accepted.

Top module: `ustore_buf`

## Requirements
- R1: After reset the buffer is empty and the spacing counter is cleared. While idle, `stall_req` and `ext_req` are 0. A store captured right after reset is offered on `ext_req` in the very next cycle.
- R2: A store presented on `wb_st_valid` while the buffer is empty is captured at that clock edge, and `stall_req` stays 0. From the next cycle the external outputs carry the same address, data and byte enables.
- R3: A store presented while the buffer is held, in a cycle without an external accept, raises `stall_req` in that cycle. The held payload on the external outputs does not change.
- R4: The entry frees in the cycle the external side accepts it (`ext_req` and `ext_ready` both 1). A store presented in that same cycle is captured with `stall_req` at 0 and appears on the external outputs in the next cycle.
- R5: While `ext_req` is 1 and `ext_ready` is 0, `ext_req` stays 1 in the next cycle and the external payload is unchanged.
- R6: Suppose a store is accepted at cycle t and another store is held. Then `ext_req` is 0 in cycles t+1 to t+4·D−1 and is 1 at cycle t+4·D, where D is the divisor.
- R7: A divisor value of 0 gives the same spacing as a divisor of 1, which is 4 cycles.
- R8: The spacing uses the divisor value present in the cycle of the accept. Later changes to `clk_div` do not change a spacing that is already running.
- R9: With a divisor of 2 and an external side that is always ready, two stores placed at write-back eight cycles apart (seven cycles between them) cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_st_valid | input | 1 | An uncached store is at write-back; held by the pipeline while stalled |
| wb_st_addr | input | AW | Store address |
| wb_st_data | input | DW | Store data |
| wb_st_be | input | DW/8 | Store byte enables |
| clk_div | input | DIVW | External clock divisor (0 acts as 1) |
| ext_ready | input | 1 | External interface accepts the offered store |
| stall_req | output | 1 | Pipeline must hold the store at write-back |
| ext_req | output | 1 | A store is offered on the external interface |
| ext_addr | output | AW | Offered store address |
| ext_data | output | DW | Offered store data |
| ext_be | output | DW/8 | Offered store byte enables |

## Verification
The bench targets the cycle where an accept and a new store coincide. A design that freed the entry one cycle late would stall there, and one that ignored the accept would drop the new store. It measures the exact request spacing for divisors 0, 2 and 3, and also for a divisor that changes right after an accept. An off-by-one counter load would show up as a gap of 4·D±1, and sampling the divisor late would show up as the wrong spacing. It also holds `ext_ready` low and presents stores while the buffer is full. A design that overwrote the held entry would show a changed payload, and one that failed to stall would lose the second store.

// File: rtl/ustb_pkg.sv
`timescale 1ns/1ps
package ustb_pkg;

    // Occupancy of the single store entry
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/ustb_gap_timer.sv
`timescale 1ns/1ps
// Down-counter that enforces 4*divisor pipeline cycles between accepts.
module ustb_gap_timer #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    input  logic            start,
    output logic            zero
);
    localparam int CW = DIVW + 2;

    logic [DIVW-1:0] eff_div;
    logic [CW-1:0]   load_val;
    logic [CW-1:0]   cnt;

    always_comb begin
        eff_div  = (div == '0) ? DIVW'(1) : div;
        load_val = {eff_div, 2'b00} - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ustb_slot.sv
`timescale 1ns/1ps
// Payload register for the single held store.
module ustb_slot #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/ustb_ctrl.sv
`timescale 1ns/1ps
// Occupancy state machine: capture, drain, refill, stall.
module ustb_ctrl
    import ustb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wb_valid,
    input  logic gap_zero,
    input  logic ext_ready,
    output logic stall_req,
    output logic ext_req,
    output logic issue,
    output logic load_slot
);
    slot_state_e state_q;
    slot_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and next state
    always_comb begin
        ext_req   = 1'b0;
        issue     = 1'b0;
        load_slot = 1'b0;
        stall_req = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wb_valid) begin          // CAPTURE
                    load_slot = 1'b1;
                    state_d   = SLOT_HELD;
                end
            end
            SLOT_HELD: begin
                ext_req = gap_zero;
                issue   = gap_zero && ext_ready;
                if (issue && wb_valid) begin // REFILL
                    load_slot = 1'b1;
                end else if (issue) begin    // DRAIN
                    state_d = SLOT_EMPTY;
                end else if (wb_valid) begin // WAIT with stall
                    stall_req = 1'b1;
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end
endmodule

// File: rtl/ustore_buf.sv
`timescale 1ns/1ps
// Single-entry uncached store buffer between write-back and the system interface.
module ustore_buf #(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wb_st_valid,
    input  logic [AW-1:0]   wb_st_addr,
    input  logic [DW-1:0]   wb_st_data,
    input  logic [DW/8-1:0] wb_st_be,
    input  logic [DIVW-1:0] clk_div,
    input  logic            ext_ready,
    output logic            stall_req,
    output logic            ext_req,
    output logic [AW-1:0]   ext_addr,
    output logic [DW-1:0]   ext_data,
    output logic [DW/8-1:0] ext_be
);
    localparam int BW = DW / 8;
    localparam int PW = AW + DW + BW;

    logic          gap_zero;
    logic          issue;
    logic          load_slot;
    logic [PW-1:0] slot_q;

    ustb_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_st_valid),
        .gap_zero  (gap_zero),
        .ext_ready (ext_ready),
        .stall_req (stall_req),
        .ext_req   (ext_req),
        .issue     (issue),
        .load_slot (load_slot)
    );

    ustb_gap_timer #(.DIVW(DIVW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_div),
        .start (issue),
        .zero  (gap_zero)
    );

    ustb_slot #(.PW(PW)) slot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_slot),
        .d     ({wb_st_addr, wb_st_data, wb_st_be}),
        .q     (slot_q)
    );

    assign {ext_addr, ext_data, ext_be} = slot_q;

endmodule

// File: rtl/ustb_checker.sv
`timescale 1ns/1ps
module ustb_checker #(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int DIVW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wb_st_valid,
    input logic [AW-1:0]   wb_st_addr,
    input logic [DIVW-1:0] clk_div,
    input logic            ext_ready,
    input logic            stall_req,
    input logic            ext_req,
    input logic [AW-1:0]   ext_addr,
    input logic [DW-1:0]   ext_data,
    input logic [DW/8-1:0] ext_be
);
    localparam int GW = DIVW + 4;

    logic [GW-1:0]   since_acc;
    logic [DIVW+1:0] need_gap;
    logic            seen_acc;
    logic [DIVW-1:0] div_eff;

    assign div_eff = (clk_div == '0) ? DIVW'(1) : clk_div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= '0;
            need_gap  <= '0;
            seen_acc  <= 1'b0;
        end else if (ext_req && ext_ready) begin
            since_acc <= GW'(1);
            need_gap  <= {div_eff, 2'b00};
            seen_acc  <= 1'b1;
        end else if (since_acc != '1) begin
            since_acc <= since_acc + GW'(1);
        end
    end

    // R2: a store taken without stall shows up on the external outputs
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_st_valid && !stall_req) |=> (ext_addr == $past(wb_st_addr)));

    // R3: stall only for a store that is present
    assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> wb_st_valid);

    // R3: a stalled store does not overwrite the held entry
    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> ($stable(ext_addr) && $stable(ext_data) && $stable(ext_be)));

    // R4: a store arriving with an accept is never stalled
    assert_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ready && wb_st_valid) |-> !stall_req);

    // R5: an unaccepted request persists with the same payload
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ready) |=> (ext_req && $stable(ext_addr) && $stable(ext_data) && $stable(ext_be)));

    // R6: minimum spacing between accepts
    assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && ext_req) |-> (since_acc >= GW'(need_gap)));

endmodule

bind ustore_buf ustb_checker #(.AW(AW), .DW(DW), .DIVW(DIVW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_st_valid (wb_st_valid),
    .wb_st_addr  (wb_st_addr),
    .clk_div     (clk_div),
    .ext_ready   (ext_ready),
    .stall_req   (stall_req),
    .ext_req     (ext_req),
    .ext_addr    (ext_addr),
    .ext_data    (ext_data),
    .ext_be      (ext_be)
);

// File: tb/ustore_buf_tb_top.sv
`timescale 1ns/1ps
module ustore_buf_tb_top;
    localparam int AW   = 32;
    localparam int DW   = 64;
    localparam int BW   = DW / 8;
    localparam int DIVW = 3;
    localparam int NV   = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wb_st_valid = 1'b0;
    logic [AW-1:0]   wb_st_addr = '0;
    logic [DW-1:0]   wb_st_data = '0;
    logic [BW-1:0]   wb_st_be = '0;
    logic [DIVW-1:0] clk_div = 3'd2;
    logic            ext_ready = 1'b0;
    logic            stall_req;
    logic            ext_req;
    logic [AW-1:0]   ext_addr;
    logic [DW-1:0]   ext_data;
    logic [BW-1:0]   ext_be;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ustore_buf #(.AW(AW), .DW(DW), .DIVW(DIVW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wb_st_valid(wb_st_valid),
        .wb_st_addr(wb_st_addr), .wb_st_data(wb_st_data), .wb_st_be(wb_st_be),
        .clk_div(clk_div), .ext_ready(ext_ready), .stall_req(stall_req),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_data(ext_data), .ext_be(ext_be)
    );

    // Vector: {req_no[3:0], valid, tag[7:0], ready, exp_stall, exp_req, exp_tag[7:0]}, divisor 2
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 capture into empty entry
        {4'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11}, // R2 offered next cycle
        {4'd3, 1'b1, 8'h22, 1'b0, 1'b1, 1'b1, 8'h11}, // R3 second store stalls
        {4'd4, 1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 8'h11}, // R4 accept and refill
        {4'd6, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 spacing running
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00}, // R3 held, spacing not done
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00},
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00},
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00},
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00},
        {4'd3, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00},
        {4'd6, 1'b1, 8'h33, 1'b1, 1'b0, 1'b1, 8'h22}, // R6 eight cycles after accept
        {4'd4, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}  // R4 third store now held
    };

    function automatic logic [AW-1:0] addr_of(input logic [7:0] tag);
        return {24'hC0FFEE, tag};
    endfunction

    task automatic check(input logic ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] tag, input logic r);
        @(negedge clk);
        wb_st_valid = v;
        wb_st_addr  = addr_of(tag);
        wb_st_data  = {addr_of(tag), ~addr_of(tag)};
        wb_st_be    = tag;
        ext_ready   = r;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wb_st_valid = 1'b0;
        ext_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_payload(input string rq, input logic [7:0] tag);
        check(ext_addr == addr_of(tag), rq, "ext_addr", 64'(ext_addr), 64'(addr_of(tag)));
        check(ext_data == {addr_of(tag), ~addr_of(tag)}, rq, "ext_data",
              ext_data, {addr_of(tag), ~addr_of(tag)});
        check(ext_be == tag, rq, "ext_be", 64'(ext_be), 64'(tag));
    endtask

    // Accept at cycle 0 with a refill store, then count cycles to the next request
    task automatic gap_run(input logic [DIVW-1:0] d_issue, input logic [DIVW-1:0] d_after,
                           input int exp_gap, input string rq);
        int got;
        got = -1;
        do_reset();
        clk_div = d_issue;
        step(1'b1, 8'h40, 1'b0);
        step(1'b1, 8'h41, 1'b1);
        check(ext_req == 1'b1 && stall_req == 1'b0, "R4", "accept with refill",
              {62'd0, ext_req, stall_req}, 64'd2);
        for (int k = 1; k <= 64; k++) begin
            step(1'b0, 8'h00, 1'b1);
            if (k == 1) clk_div = d_after;
            if (ext_req && got < 0) begin
                got = k;
                check_payload("R4", 8'h41);
                break;
            end
        end
        check(got == exp_gap, rq, "request spacing", 64'(got), 64'(exp_gap));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and idle behaviour
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 8'h00, 1'b1);
            check(!stall_req && !ext_req, "R1", "idle outputs",
                  {62'd0, stall_req, ext_req}, 64'd0);
        end

        // Table walk, divisor 2
        clk_div = 3'd2;
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i][23:20]);
            step(VEC[i][19], VEC[i][18:11], VEC[i][10]);
            check(stall_req == VEC[i][9], rq, $sformatf("stall_req v%0d", i),
                  64'(stall_req), 64'(VEC[i][9]));
            check(ext_req == VEC[i][8], rq, $sformatf("ext_req v%0d", i),
                  64'(ext_req), 64'(VEC[i][8]));
            if (VEC[i][8]) check_payload(rq, VEC[i][7:0]);
        end

        // R5: request held while not ready
        do_reset();
        step(1'b1, 8'h5A, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h00, 1'b0);
            check(ext_req == 1'b1, "R5", "request held", 64'(ext_req), 64'd1);
            check_payload("R5", 8'h5A);
        end

        // R1: reset while held clears entry and timer
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!ext_req && !stall_req, "R1", "outputs in reset",
              {62'd0, stall_req, ext_req}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b1);
        check(!ext_req, "R1", "empty after reset", 64'(ext_req), 64'd0);
        step(1'b1, 8'h61, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        check(ext_req == 1'b1, "R1", "offered right after capture", 64'(ext_req), 64'd1);
        check_payload("R2", 8'h61);

        // R6, R7, R8: exact spacing
        gap_run(3'd2, 3'd2, 8, "R6");
        gap_run(3'd3, 3'd3, 12, "R6");
        gap_run(3'd0, 3'd0, 4, "R7");
        gap_run(3'd1, 3'd7, 4, "R8");

        // R9: seven cycles between stores at divisor 2, no stall
        do_reset();
        clk_div = 3'd2;
        step(1'b1, 8'h70, 1'b1);
        check(!stall_req, "R9", "first store", 64'(stall_req), 64'd0);
        step(1'b0, 8'h00, 1'b1);
        check(ext_req == 1'b1, "R9", "first offered", 64'(ext_req), 64'd1);
        for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'h71, 1'b1);
        check(!stall_req, "R9", "second store no stall", 64'(stall_req), 64'd0);
        step(1'b0, 8'h00, 1'b1);
        check(ext_req == 1'b1, "R9", "second offered", 64'(ext_req), 64'd1);
        check_payload("R9", 8'h71);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule